// File: doc/BRIEF.md
# Staged Core Power Clamp Sequencer

This block drives the 8-bit clamp code of the power switch that feeds one CPU core. A code of 0x00 lets the switch conduct fully and a code of 0xFF holds it fully off. Turning the switch on walks the clamp through a short ladder of partial codes, each held for a fixed number of microseconds, so the rail charges in stages and the inrush current stays bounded. Turning it off drops straight back to 0xFF and then waits out a settling period.

The controller above the block raises a one-cycle open or close request. The block reports `busy` for as long as a sequence runs and then gives a one-cycle `done`. The hold time follows from two parameters: the clock cycles per microsecond and the hold length in microseconds. An open request that finds the switch already conducting completes at once and does not replay the ladder.

Top module: `core_clamp_seq`

## Requirements
- R1: During and after reset, `clamp_code` is 0xFF (off), `busy` is 0 and `done` is 0.
- R2: An accepted open request makes `clamp_code` take the values 0xFF, 0xFE, 0xF8, 0xF0 and 0x00 in that order. 0x00 is fully conducting and 0xFF is fully clamped off. The first value appears on the cycle after the request is sampled.
- R3: In an open sequence each code is held for exactly HOLD_US*CYC_PER_US cycles. `busy` is high for all 5*HOLD_US*CYC_PER_US cycles, and `done` is high on the cycle after that.
- R4: An open request sampled while idle with `clamp_code` at 0x00 gives `done` on the next cycle. `busy` stays low and `clamp_code` stays at 0x00.
- R5: An accepted close request sets `clamp_code` to 0xFF on the next cycle, in one step, even if it was already 0xFF. `busy` then stays high for HOLD_US*CYC_PER_US cycles, and `done` follows on the cycle after.
- R6: `done` is never high for two cycles in a row, it is never high together with `busy`, and `busy` only falls with `done` high.
- R7: Open and close requests sampled while `busy` is high are ignored. The code sequence, its timing and the final code are the same as with no such request.
- R8: When open and close are requested in the same idle cycle, open wins and close is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| open_req | input | 1 | Request to switch the core rail on (sampled when idle) |
| close_req | input | 1 | Request to switch the core rail off (sampled when idle) |
| busy | output | 1 | High while a sequence is running |
| done | output | 1 | One-cycle pulse when a request completes |
| clamp_code | output | 8 | Clamp code driven to the power switch |

## Verification
The assertions assume that requests are plain synchronous levels that hold steady for a whole cycle. They also assume that reset is applied from time zero, so the clamp history starts from the off code. The bench changes requests only on the falling edge and returns them to zero before the cycle in which `done` shows, so a new request is never sampled at the same moment a sequence completes. Random requests are injected only during cycles in which the block is busy, which exercises the rule that such requests are ignored without making the expected trace ambiguous.

// File: rtl/ccs_pkg.sv
package ccs_pkg;

    localparam int CLAMP_W   = 8;
    localparam int NUM_STEPS = 5;
    localparam int STEP_W    = $clog2(NUM_STEPS);

    typedef logic [CLAMP_W-1:0] clamp_t;
    typedef logic [STEP_W-1:0]  step_idx_t;

    localparam clamp_t CLAMP_OFF = 8'hFF;
    localparam clamp_t CLAMP_ON  = 8'h00;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_OPEN  = 2'd1,
        ST_CLOSE = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        CMD_KEEP  = 2'd0,
        CMD_START = 2'd1,
        CMD_NEXT  = 2'd2,
        CMD_SHUT  = 2'd3
    } step_cmd_e;

    // Clamp code applied at each rung of the opening ladder.
    function automatic clamp_t ladder_code(input step_idx_t idx);
        clamp_t c;
        case (idx)
            3'd0:    c = 8'hFF;
            3'd1:    c = 8'hFE;
            3'd2:    c = 8'hF8;
            3'd3:    c = 8'hF0;
            3'd4:    c = 8'h00;
            default: c = CLAMP_OFF;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/ccs_hold_timer.sv
module ccs_hold_timer #(
    parameter int HOLD_CYC = 2500
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    output logic last
);
    localparam int CNT_W = $clog2(HOLD_CYC) + 1;
    localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(HOLD_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last = (cnt_q == LAST_VAL);

endmodule

// File: rtl/ccs_step_reg.sv
module ccs_step_reg
    import ccs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  step_cmd_e cmd,
    output clamp_t    clamp,
    output logic      step_last,
    output logic      clamp_on
);
    step_idx_t idx_q;
    clamp_t    clamp_q;
    step_idx_t idx_nx;

    assign idx_nx = STEP_W'(idx_q + 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q   <= '0;
            clamp_q <= CLAMP_OFF;
        end else begin
            case (cmd)
                CMD_START: begin
                    idx_q   <= '0;
                    clamp_q <= ladder_code('0);
                end
                CMD_NEXT: begin
                    idx_q   <= idx_nx;
                    clamp_q <= ladder_code(idx_nx);
                end
                CMD_SHUT: begin
                    idx_q   <= '0;
                    clamp_q <= CLAMP_OFF;
                end
                default: begin
                    idx_q   <= idx_q;
                    clamp_q <= clamp_q;
                end
            endcase
        end
    end

    assign clamp     = clamp_q;
    assign step_last = (idx_q == STEP_W'(NUM_STEPS - 1));
    assign clamp_on  = (clamp_q == CLAMP_ON);

endmodule

// File: rtl/ccs_ctrl.sv
module ccs_ctrl
    import ccs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      open_req,
    input  logic      close_req,
    input  logic      clamp_on,
    input  logic      hold_last,
    input  logic      step_last,
    output step_cmd_e cmd,
    output logic      hold_clear,
    output logic      busy,
    output logic      done
);
    seq_state_e state_q, state_d;
    logic       done_q, done_d;

    always_comb begin
        state_d    = state_q;
        cmd        = CMD_KEEP;
        done_d     = 1'b0;
        hold_clear = 1'b1;
        case (state_q)
            ST_IDLE: begin
                if (open_req) begin
                    if (clamp_on) begin
                        done_d = 1'b1;
                    end else begin
                        state_d = ST_OPEN;
                        cmd     = CMD_START;
                    end
                end else if (close_req) begin
                    state_d = ST_CLOSE;
                    cmd     = CMD_SHUT;
                end
            end
            ST_OPEN: begin
                hold_clear = hold_last;
                if (hold_last) begin
                    if (step_last) begin
                        state_d = ST_IDLE;
                        done_d  = 1'b1;
                    end else begin
                        cmd = CMD_NEXT;
                    end
                end
            end
            ST_CLOSE: begin
                hold_clear = hold_last;
                if (hold_last) begin
                    state_d = ST_IDLE;
                    done_d  = 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= done_d;
        end
    end

    assign busy = (state_q != ST_IDLE);
    assign done = done_q;

endmodule

// File: rtl/core_clamp_seq.sv
module core_clamp_seq
    import ccs_pkg::*;
#(
    parameter int CYC_PER_US = 250,
    parameter int HOLD_US    = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               open_req,
    input  logic               close_req,
    output logic               busy,
    output logic               done,
    output logic [CLAMP_W-1:0] clamp_code
);
    localparam int HOLD_CYC = CYC_PER_US * HOLD_US;

    step_cmd_e cmd;
    logic      hold_clear;
    logic      hold_last;
    logic      step_last;
    logic      clamp_on;
    clamp_t    clamp;

    ccs_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .open_req   (open_req),
        .close_req  (close_req),
        .clamp_on   (clamp_on),
        .hold_last  (hold_last),
        .step_last  (step_last),
        .cmd        (cmd),
        .hold_clear (hold_clear),
        .busy       (busy),
        .done       (done)
    );

    ccs_hold_timer #(
        .HOLD_CYC (HOLD_CYC)
    ) u_timer (
        .clk   (clk),
        .rst   (rst),
        .clear (hold_clear),
        .last  (hold_last)
    );

    ccs_step_reg u_steps (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .clamp     (clamp),
        .step_last (step_last),
        .clamp_on  (clamp_on)
    );

    assign clamp_code = clamp;

endmodule

// File: rtl/ccs_checker.sv
module ccs_checker #(
    parameter int CYC_PER_US = 250,
    parameter int HOLD_US    = 10
) (
    input logic       clk,
    input logic       rst,
    input logic       open_req,
    input logic       close_req,
    input logic       busy,
    input logic       done,
    input logic [7:0] clamp_code
);
    localparam int HOLD_CYC = CYC_PER_US * HOLD_US;
    localparam int OPEN_CYC = 5 * HOLD_CYC;

    // Length of the most recent run of busy cycles.
    int busy_len;
    always_ff @(posedge clk) begin
        if (rst) begin
            busy_len <= 0;
        end else if (busy) begin
            busy_len <= busy_len + 1;
        end else begin
            busy_len <= 0;
        end
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (clamp_code == 8'hFF && !busy && !done));

    assert_ladder_order_R2: assert property (@(posedge clk) disable iff (rst)
        !$stable(clamp_code) |->
            (clamp_code == 8'hFF) ||
            ($past(clamp_code) == 8'hFF && clamp_code == 8'hFE) ||
            ($past(clamp_code) == 8'hFE && clamp_code == 8'hF8) ||
            ($past(clamp_code) == 8'hF8 && clamp_code == 8'hF0) ||
            ($past(clamp_code) == 8'hF0 && clamp_code == 8'h00));

    assert_start_off_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> clamp_code == 8'hFF);

    assert_run_length_R3: assert property (@(posedge clk) disable iff (rst)
        done |-> (busy_len == 0 || busy_len == HOLD_CYC || busy_len == OPEN_CYC));

    assert_fast_open_R4: assert property (@(posedge clk) disable iff (rst)
        (open_req && !busy && clamp_code == 8'h00) |=>
            (done && !busy && clamp_code == 8'h00));

    assert_close_entry_R5: assert property (@(posedge clk) disable iff (rst)
        (close_req && !open_req && !busy) |=> (busy && clamp_code == 8'hFF));

    assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_idle_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_busy_ends_done_R6: assert property (@(posedge clk) disable iff (rst)
        busy |=> (busy || done));

endmodule

bind core_clamp_seq ccs_checker #(
    .CYC_PER_US (CYC_PER_US),
    .HOLD_US    (HOLD_US)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .open_req   (open_req),
    .close_req  (close_req),
    .busy       (busy),
    .done       (done),
    .clamp_code (clamp_code)
);

// File: tb/core_clamp_seq_tb_top.sv
`timescale 1ns/1ps
module core_clamp_seq_tb_top;

    localparam int CPU = 2;
    localparam int HUS = 10;
    localparam int H   = CPU * HUS;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       open_req = 1'b0;
    logic       close_req = 1'b0;
    logic       busy;
    logic       done;
    logic [7:0] clamp_code;

    int n_vec = 0;
    int n_bad = 0;
    logic [7:0] model_clamp = 8'hFF;

    always #2 clk = ~clk;

    core_clamp_seq #(.CYC_PER_US(CPU), .HOLD_US(HUS)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .open_req   (open_req),
        .close_req  (close_req),
        .busy       (busy),
        .done       (done),
        .clamp_code (clamp_code)
    );

    function automatic logic [7:0] exp_code(input int rung);
        case (rung)
            0:       return 8'hFF;
            1:       return 8'hFE;
            2:       return 8'hF8;
            3:       return 8'hF0;
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
        end
    endtask

    // kind: 0 open, 1 close, 2 both at once
    task automatic do_op(input int kind, input bit noise);
        bit         is_open;
        bit         fast;
        int         len;
        logic [7:0] final_code;
        string      tag;
        @(negedge clk);
        open_req  = (kind != 1);
        close_req = (kind != 0);
        is_open   = (kind != 1);
        fast      = is_open && (model_clamp == 8'h00);
        len       = is_open ? 5 * H : H;
        tag       = (kind == 2) ? "R8" : (is_open ? "R2" : "R5");
        @(negedge clk);
        open_req  = 1'b0;
        close_req = 1'b0;
        if (fast) begin
            check((kind == 2) ? "R8" : "R4", {31'd0, done}, 32'd1);
            check("R4", {31'd0, busy}, 32'd0);
            check("R4", {24'd0, clamp_code}, 32'h00);
            @(negedge clk);
            check("R6", {31'd0, done}, 32'd0);
            return;
        end
        for (int c = 1; c <= len; c++) begin
            if (c > 1) @(negedge clk);
            check(tag, {24'd0, clamp_code},
                  {24'd0, is_open ? exp_code((c - 1) / H) : 8'hFF});
            check("R3", {31'd0, busy}, 32'd1);
            check("R6", {31'd0, done}, 32'd0);
            if (noise) begin
                open_req  = ($urandom % 3) == 0;
                close_req = ($urandom % 3) == 0;
            end
        end
        @(negedge clk);
        open_req   = 1'b0;
        close_req  = 1'b0;
        final_code = is_open ? 8'h00 : 8'hFF;
        check(noise ? "R7" : "R3", {31'd0, done}, 32'd1);
        check("R6", {31'd0, busy}, 32'd0);
        check(noise ? "R7" : tag, {24'd0, clamp_code}, {24'd0, final_code});
        model_clamp = final_code;
        @(negedge clk);
        check("R6", {31'd0, done}, 32'd0);
        check("R6", {31'd0, busy}, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1;
        repeat (3) @(negedge clk);
        // R1: state held in reset
        check("R1", {24'd0, clamp_code}, 32'hFF);
        check("R1", {31'd0, busy}, 32'd0);
        check("R1", {31'd0, done}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", {24'd0, clamp_code}, 32'hFF);

        do_op(1, 1'b0);   // R5: close from off still waits
        do_op(0, 1'b0);   // R2/R3: full ladder
        do_op(0, 1'b0);   // R4: already on
        do_op(2, 1'b0);   // R8: both while on, open wins -> fast finish
        do_op(1, 1'b1);   // R7: close with noise
        do_op(2, 1'b0);   // R8: both while off, ladder runs
        do_op(1, 1'b0);
        do_op(0, 1'b1);   // R7: open with noise

        for (int i = 0; i < 30; i++) begin
            int gap;
            gap = $urandom % 4;
            repeat (gap) @(negedge clk);
            do_op($urandom % 3, 1'($urandom % 2));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule